// File: doc/BRIEF.md
# Torn-Read Tolerant Counter Sampler

This sequencer captures a 30-bit free-running down-counter that software-side logic can only reach one byte at a time. The counter sits behind two indexed byte windows, a primary and a secondary. Each byte is fetched in three steps: an index write, a data read request, and the returned byte. The four bytes are packed into one 30-bit word.

The upper bytes may change between the byte reads, so one pass can yield a torn value. The sequencer therefore repeats the whole pass until two consecutive samples agree in their upper field and the later sample is not larger than the earlier one. It stops after a fixed number of extra passes and returns the last sample whether or not it passed the test. A single start pulse launches the operation. A one-cycle done pulse presents the result.

The bus request channel is valid/ready. Once the request valid is raised, it stays high until ready is seen. The write flag, the channel select and the data stay unchanged until that point. A transfer completes on any clock edge where valid and ready are both high. The response channel has no back-pressure: the sequencer always accepts a response while it waits for one, and it ignores the response valid at all other times.

Top module: `cnt_snap_reader`

## Requirements
- R1: Each sample is made of four byte accesses, always in this order: channel 0 index 0x20, channel 0 index 0x21, channel 1 index 0x20, channel 1 index 0x21. Each access is an index write (write flag 1, data = index), then a data read (write flag 0), then one response byte.
- R2: While request valid is high and ready is low, valid stays high and the write flag, the channel and the data hold their values.
- R3: The four bytes b0..b3, in access order, are packed as (b3<<23)|(b2<<15)|(b1<<8)|b0, and the result is cut to 30 bits. Bit 7 of b3 is discarded.
- R4: After a sample, another full sample is taken when the bits 29:15 of the previous and current samples differ, or when the previous value is less than the current one.
- R5: The previous value used for the first sample of an operation is zero, so a first sample of zero ends the operation after one pass.
- R6: At most three retries follow the first sample, so there are at most four samples. The fourth sample is returned even if the test still asks for another pass.
- R7: done_o is a one-cycle pulse. busy_o is low while done_o is high. count_o changes only together with done_o.
- R8: A start pulse that arrives while busy_o is high is ignored, and no extra samples or done pulse result from it.
- R9: After reset, busy_o, done_o and the request valid are low, and count_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that starts one capture |
| busy_o | output | 1 | High while a capture is in progress |
| done_o | output | 1 | One-cycle pulse: count_o holds the new result |
| count_o | output | 30 | Last captured counter value |
| bus_req_valid_o | output | 1 | Bus request valid |
| bus_req_ready_i | input | 1 | Bus request ready |
| bus_req_write_o | output | 1 | 1 = index write, 0 = data read |
| bus_req_chan_o | output | 1 | Window select: 0 primary, 1 secondary |
| bus_req_data_o | output | 8 | Index value for a write request |
| bus_rsp_valid_i | input | 1 | Read data valid |
| bus_rsp_data_i | input | 8 | Read data byte |

## Verification
A wrong byte counter or channel select would show up at the request port on the very next access, as an index out of sequence. It would also show up as wrong data in the packed result. A broken retry decision or retry counter would not show on the bus until the end of the operation. It then appears as the wrong number of four-byte passes before done, and usually as the wrong returned value. A fault in the request-hold logic would show on the first cycle of back-pressure, as a request that changed while it was waiting for ready.

// File: rtl/cnt_snap_pkg.sv
package cnt_snap_pkg;
  localparam int CNT_W  = 30;
  localparam int BYTE_W = 8;
  localparam int NBYTES = 4;

  typedef enum logic [1:0] {F_IDLE, F_IDX, F_RD, F_RSP} fetch_st_t;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_JUDGE} seq_st_t;

  // Overlapping byte placement: byte 2 starts at bit 15, byte 3 at bit 23.
  function automatic logic [CNT_W-1:0] pack_bytes(
    input logic [BYTE_W-1:0] b0, input logic [BYTE_W-1:0] b1,
    input logic [BYTE_W-1:0] b2, input logic [BYTE_W-1:0] b3);
    logic [CNT_W:0] w;
    w = {b3, 23'd0} | {8'd0, b2, 15'd0} | {15'd0, b1, 8'd0} | {23'd0, b0};
    return w[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/cnt_snap_fetch.sv
module cnt_snap_fetch
  import cnt_snap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          chan_i,
  input  logic [DW-1:0] idx_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic          req_chan_o,
  output logic [DW-1:0] req_data_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          byte_valid_o,
  output logic [DW-1:0] byte_o
);
  fetch_st_t       st;
  logic            chan_q;
  logic [DW-1:0]   idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      chan_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      case (st)
        F_IDLE: if (go_i) begin
          chan_q <= chan_i;
          idx_q  <= idx_i;
          st     <= F_IDX;
        end
        F_IDX:  if (req_ready_i) st <= F_RD;
        F_RD:   if (req_ready_i) st <= F_RSP;
        F_RSP:  if (rsp_valid_i) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign req_valid_o  = (st == F_IDX) || (st == F_RD);
  assign req_write_o  = (st == F_IDX);
  assign req_chan_o   = chan_q;
  assign req_data_o   = (st == F_IDX) ? idx_q : '0;
  assign byte_valid_o = (st == F_RSP) && rsp_valid_i;
  assign byte_o       = rsp_data_i;
endmodule

// File: rtl/cnt_snap_judge.sv
module cnt_snap_judge #(
  parameter int W      = 30,
  parameter int HI_LSB = 15
) (
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] cur_i,
  output logic         again_o
);
  logic hi_diff;
  logic went_up;
  assign hi_diff = (prev_i[W-1:HI_LSB] != cur_i[W-1:HI_LSB]);
  assign went_up = (prev_i < cur_i);
  assign again_o = hi_diff || went_up;
endmodule

// File: rtl/cnt_snap_reader.sv
module cnt_snap_reader
  import cnt_snap_pkg::*;
#(
  parameter int          MAX_RETRY = 3,
  parameter logic [7:0]  IDX_LO    = 8'h20,
  parameter logic [7:0]  IDX_HI    = 8'h21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic             bus_req_valid_o,
  input  logic             bus_req_ready_i,
  output logic             bus_req_write_o,
  output logic             bus_req_chan_o,
  output logic [7:0]       bus_req_data_o,
  input  logic             bus_rsp_valid_i,
  input  logic [7:0]       bus_rsp_data_i
);
  localparam int RW = $clog2(MAX_RETRY + 2);
  localparam int KW = $clog2(NBYTES);

  seq_st_t           st;
  logic [KW-1:0]     k_q;
  logic [RW-1:0]     nretry_q;
  logic [CNT_W-1:0]  prev_q;
  logic [BYTE_W-1:0] bytes_q [NBYTES];
  logic [CNT_W-1:0]  cur;
  logic              again;
  logic              go;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_d;
  logic [7:0]        idx_sel;

  assign go      = (st == S_ISSUE);
  assign idx_sel = k_q[0] ? IDX_HI : IDX_LO;
  assign cur     = pack_bytes(bytes_q[0], bytes_q[1], bytes_q[2], bytes_q[3]);
  assign busy_o  = (st != S_IDLE);

  cnt_snap_fetch #(.DW(BYTE_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go),
    .chan_i       (k_q[KW-1]),
    .idx_i        (idx_sel),
    .req_valid_o  (bus_req_valid_o),
    .req_ready_i  (bus_req_ready_i),
    .req_write_o  (bus_req_write_o),
    .req_chan_o   (bus_req_chan_o),
    .req_data_o   (bus_req_data_o),
    .rsp_valid_i  (bus_rsp_valid_i),
    .rsp_data_i   (bus_rsp_data_i),
    .byte_valid_o (byte_vld),
    .byte_o       (byte_d)
  );

  cnt_snap_judge #(.W(CNT_W), .HI_LSB(15)) u_judge (
    .prev_i  (prev_q),
    .cur_i   (cur),
    .again_o (again)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      k_q      <= '0;
      nretry_q <= '0;
      prev_q   <= '0;
      count_o  <= '0;
      done_o   <= 1'b0;
      for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          prev_q   <= '0;
          nretry_q <= '0;
          k_q      <= '0;
          st       <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (byte_vld) begin
          bytes_q[k_q] <= byte_d;
          if (k_q == KW'(NBYTES - 1)) st <= S_JUDGE;
          else begin
            k_q <= k_q + 1'b1;
            st  <= S_ISSUE;
          end
        end
        S_JUDGE: begin
          if (again && (nretry_q < RW'(MAX_RETRY))) begin
            prev_q   <= cur;
            nretry_q <= nretry_q + 1'b1;
            k_q      <= '0;
            st       <= S_ISSUE;
          end else begin
            count_o <= cur;
            done_o  <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cnt_snap_checker.sv
module cnt_snap_checker #(
  parameter logic [7:0] IDX_LO = 8'h20,
  parameter logic [7:0] IDX_HI = 8'h21
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic [29:0] count_o,
  input logic        bus_req_valid_o,
  input logic        bus_req_ready_i,
  input logic        bus_req_write_o,
  input logic        bus_req_chan_o,
  input logic [7:0]  bus_req_data_o
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid_o && !bus_req_ready_i |=> bus_req_valid_o && $stable(bus_req_write_o)
      && $stable(bus_req_chan_o) && $stable(bus_req_data_o));

  assert_index_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid_o && bus_req_write_o |-> (bus_req_data_o == IDX_LO) || (bus_req_data_o == IDX_HI));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_value_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_o) |-> done_o);

  assert_req_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid_o |-> busy_o);

  assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> busy_o || done_o);
endmodule

bind cnt_snap_reader cnt_snap_checker #(.IDX_LO(IDX_LO), .IDX_HI(IDX_HI)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .count_o         (count_o),
  .bus_req_valid_o (bus_req_valid_o),
  .bus_req_ready_i (bus_req_ready_i),
  .bus_req_write_o (bus_req_write_o),
  .bus_req_chan_o  (bus_req_chan_o),
  .bus_req_data_o  (bus_req_data_o)
);

// File: tb/test_cnt_snap_reader.sv
module test_cnt_snap_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        busy_o, done_o;
  logic [29:0] count_o;
  logic        req_valid, req_ready = 1'b0, req_write, req_chan;
  logic [7:0]  req_data;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;

  always #5 clk = ~clk;

  cnt_snap_reader i_cnt_snap_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .count_o(count_o), .bus_req_valid_o(req_valid), .bus_req_ready_i(req_ready),
    .bus_req_write_o(req_write), .bus_req_chan_o(req_chan), .bus_req_data_o(req_data),
    .bus_rsp_valid_i(rsp_valid), .bus_rsp_data_i(rsp_data));

  int n_cmp = 0, n_bad = 0;
  logic [29:0] script [4];
  int script_n = 1;
  bit set_b30 = 0, bp_on = 0;
  int served = 0, smp_idx = 0, pos = 0;
  logic [7:0] cur_idx [2];
  logic [15:0] lfsr = 16'hACE1;
  bit rd_pend = 0;
  logic [7:0] pend_data;
  logic [29:0] exp_val_q [$];
  int exp_smp_q [$];
  string tag_q [$];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [7:0] byte_for(int s, logic ch, logic [7:0] ix);
    logic [29:0] v = script[s];
    if (!ch && ix == 8'h20) return v[7:0];
    if (!ch && ix == 8'h21) return v[15:8];
    if (ch && ix == 8'h20)  return v[22:15];
    if (ch && ix == 8'h21)  return {set_b30, v[29:23]};
    return 8'hEE;
  endfunction

  // Bus slave: decides ready and answers reads away from the active edge.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rd_pend) begin rsp_valid = 1'b1; rsp_data = pend_data; rd_pend = 0; end
    else rsp_valid = 1'b0;
    req_ready = bp_on ? lfsr[0] : 1'b1;
    if (rst_n && req_valid && req_ready) begin
      if (req_write) cur_idx[req_chan] = req_data;
      else begin
        logic ech; logic [7:0] eix;
        ech = (pos >= 2);
        eix = (pos % 2 == 1) ? 8'h21 : 8'h20;
        n_cmp++;
        if (req_chan !== ech || cur_idx[req_chan] !== eix) begin
          n_bad++;
          $display("FAIL R1 access order: got chan %0d idx %h, expected chan %0d idx %h",
                   req_chan, cur_idx[req_chan], ech, eix);
        end
        pend_data = byte_for(smp_idx, req_chan, cur_idx[req_chan]);
        rd_pend = 1;
        pos++;
        if (pos == 4) begin
          pos = 0; served++;
          if (smp_idx < script_n - 1) smp_idx++;
        end
      end
    end
  end

  // Monitor: pops expectations when a result appears.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_val_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R8 unexpected done: got value %h, expected no result", count_o);
      end else begin
        logic [29:0] ev; int es; string tg;
        ev = exp_val_q.pop_front(); es = exp_smp_q.pop_front(); tg = tag_q.pop_front();
        n_cmp++;
        if (count_o !== ev) begin
          n_bad++; $display("FAIL %s value: got %h, expected %h", tg, count_o, ev);
        end
        n_cmp++;
        if (served != es) begin
          n_bad++; $display("FAIL %s samples: got %0d, expected %0d", tg, served, es);
        end
        n_cmp++;
        if (busy_o !== 1'b0) begin
          n_bad++; $display("FAIL R7 busy during done: got %b, expected 0", busy_o);
        end
      end
    end
  end

  task automatic run_case(input logic [29:0] a, input logic [29:0] b, input logic [29:0] c,
                          input logic [29:0] d, input int n, input bit b30, input bit bp,
                          input bit dbl, input string tg);
    logic [29:0] last, cur;
    int k, smp;
    script[0] = a; script[1] = b; script[2] = c; script[3] = d;
    script_n = n; set_b30 = b30; bp_on = bp;
    last = '0; k = 0; smp = 0;
    while (1) begin
      cur = script[(k < n) ? k : n - 1];
      smp++;
      if (k < 3 && ((((last ^ cur) & 30'h3FFF8000) != 0) || last < cur)) begin
        last = cur; k++;
      end else break;
    end
    exp_val_q.push_back(cur); exp_smp_q.push_back(smp); tag_q.push_back(tg);
    served = 0; smp_idx = 0; pos = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (dbl) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    wait (exp_val_q.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    cur_idx[0] = 8'h00; cur_idx[1] = 8'h00;
    repeat (3) @(negedge clk);
    // R9 reset state
    n_cmp++; if (busy_o !== 1'b0 || done_o !== 1'b0) begin n_bad++;
      $display("FAIL R9 busy/done: got %b/%b, expected 0/0", busy_o, done_o); end
    n_cmp++; if (req_valid !== 1'b0) begin n_bad++;
      $display("FAIL R9 req_valid: got %b, expected 0", req_valid); end
    n_cmp++; if (count_o !== 30'd0) begin n_bad++;
      $display("FAIL R9 count: got %h, expected 0", count_o); end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(30'h0, 30'h0, 30'h0, 30'h0, 1, 0, 0, 0, "R5 zero first");
    run_case(30'h12345678, 30'h12345678, 30'h0, 30'h0, 2, 0, 0, 0, "R4 stable");
    run_case(30'h12345678, 30'h12345600, 30'h0, 30'h0, 2, 0, 0, 0, "R4 decreasing");
    run_case(30'h02000000, 30'h01FF8000, 30'h01FF8000, 30'h0, 3, 0, 0, 0, "R4 high change");
    run_case(30'h00100010, 30'h00100020, 30'h00100020, 30'h0, 3, 0, 0, 0, "R4 increase");
    run_case(30'h30000000, 30'h20000000, 30'h10000000, 30'h08000000, 4, 0, 0, 0, "R6 no settle");
    run_case(30'h00000005, 30'h00000006, 30'h00000007, 30'h00000008, 4, 0, 0, 0, "R6 rising");
    run_case(30'h3FFFFFFF, 30'h3FFFFFFF, 30'h0, 30'h0, 2, 1, 0, 0, "R3 bit30 drop");
    run_case(30'h2ABD8F35, 30'h2ABD8F35, 30'h0, 30'h0, 2, 0, 0, 0, "R3 packing");
    run_case(30'h02000000, 30'h01FF8000, 30'h01FF8000, 30'h0, 3, 0, 1, 0, "R2 backpressure");
    run_case(30'h00ABCDEF, 30'h00ABCDEF, 30'h0, 30'h0, 2, 0, 0, 1, "R8 start while busy");
    n_cmp++; if (busy_o !== 1'b0) begin n_bad++;
      $display("FAIL R8 idle after ignored start: got %b, expected 0", busy_o); end

    summary();
    $finish;
  end
endmodule